// File: doc/BRIEF.md
# Receive Descriptor Scatter Engine

This engine sits between a receive MAC and system memory. Frame bytes arrive one at a time on a valid/last stream. The engine places them into the data buffers of a ring of receive descriptors that software has prepared in memory. It adds a four-byte Ethernet frame check sequence after the payload, and it writes the byte count and status of each descriptor it fills back into that descriptor.

Each descriptor takes eight bytes. The word at offset 0 is `{flags[15:0], length[15:0]}`. The word at offset 4 is the buffer pointer. Word accesses are aligned, and the most significant byte sits at the lowest address. Software loads the ring start, the buffer size, the maximum frame length and the enable bit. It then pulses the activate strobe. The engine reads the current descriptor to decide whether reception is active. While reception is inactive, whole frames are consumed and dropped. The memory port completes every access in the cycle that requests it, and read data must be valid in that same cycle.

Top module: `rxbd_engine`

## Requirements
- R1: Payload bytes are written in arrival order, one byte per accepted input beat, starting at the descriptor's buffer pointer. `in_ready` is low in every cycle that makes a descriptor word access.
- R2: The check sequence is CRC-32 over all payload bytes: reflected polynomial 0xEDB88320, initial value all ones, result complemented. Its four bytes are stored right after the payload, least significant byte first. They count toward the frame size and may continue into the next descriptor.
- R3: When payload plus 4 exceeds 2032, the engine stores only the first 2028 payload bytes followed by the check sequence. The final descriptor then carries the truncated flag (bit 0) and the length-error flag (bit 5).
- R4: Each descriptor receives the smaller of the bytes still to store and the buffer size. The buffer size is the written value with bits 3:0 forced to zero; only bits 10:4 are kept.
- R5: On write-back, flags bit 15 (empty) is cleared and the other flag bits read from the descriptor are kept. The length field gets the byte count of that descriptor.
- R6: Only the descriptor holding the end of the frame gets the last flag (bit 11) and any error flags, and its write-back pulses `ev_frame`. Every earlier descriptor pulses `ev_buffer` instead.
- R7: The length-error flag is set when the stored frame size, check sequence included, is greater than `cfg_max_len`.
- R8: If a descriptor is found not empty partway through a frame, nothing more of that frame is stored, that descriptor is left untouched, and reception becomes inactive.
- R9: After a completed frame, `rx_active` equals the empty bit of the next descriptor. While `rx_active` is low, incoming frames cause no memory write and no event.
- R10: `act_wr` re-reads the current descriptor only when `cfg_enable` is high and reception is inactive. A low `cfg_enable` forces `rx_active` low from the next cycle on.
- R11: After a descriptor with the wrap flag (bit 13) set, the next descriptor is the ring start. Otherwise the next descriptor is the current address plus 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Marks the final payload byte |
| in_ready | output | 1 | Engine accepts the byte this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_word | output | 1 | 1 = 32-bit word access, 0 = single byte in mem_wdata[7:0] |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the requesting cycle |
| cfg_enable | input | 1 | Controller enable |
| cfg_ring_base | input | AW | Ring start address |
| cfg_ring_load | input | 1 | Loads ring start as current descriptor |
| cfg_buf_size | input | BSW | Buffer size, low 4 bits ignored |
| cfg_max_len | input | 16 | Maximum frame length |
| act_wr | input | 1 | Receive-activate strobe |
| rx_active | output | 1 | Reception active |
| ev_frame | output | 1 | Pulse: frame's final descriptor written back |
| ev_buffer | output | 1 | Pulse: non-final descriptor written back |

## Verification
The hardest case to reach is a descriptor that is not empty in the middle of a frame. The bench gets there by marking the descriptor that follows the current one as software-owned and then sending a frame longer than one buffer. Frame lengths are picked so that the check sequence lands wholly in one buffer in some frames and straddles a buffer boundary in others. A frame of 2040 bytes drives the truncation path.

// File: rtl/rxbd_pkg.sv
// Shared definitions for the receive descriptor engine.
// Assumes the descriptor flag layout given in the brief.
package rxbd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a frame or an activate strobe
        ST_SKIP,   // dropping a frame while inactive
        ST_RD0,    // reading descriptor flags/length word
        ST_RD1,    // reading descriptor buffer pointer
        ST_DATA,   // storing payload and check bytes
        ST_WB,     // writing back flags and length
        ST_FLUSH,  // discarding the rest of a frame
        ST_CHK     // re-checking the current descriptor
    } rxbd_state_e;

    localparam int BIT_EMPTY  = 15;
    localparam int BIT_WRAP   = 13;
    localparam int BIT_LAST   = 11;
    localparam int BIT_LENERR = 5;
    localparam int BIT_TRUNC  = 0;
    localparam int DESC_STRIDE = 8;
    localparam int PTR_OFFSET  = 4;
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;
endpackage

// File: rtl/rxbd_crc.sv
// Byte-serial CRC-32 accumulator (reflected form).
// Assumes one byte per step; clear restarts at all ones.
module rxbd_crc
    import rxbd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        step,
    input  logic [7:0]  din,
    output logic [31:0] crc_next
);
    logic [31:0] crc_q;

    // Next CRC value after folding in one byte.
    always_comb begin
        crc_next = crc_q ^ {24'b0, din};
        for (int k = 0; k < 8; k++) begin
            crc_next = crc_next[0] ? ((crc_next >> 1) ^ CRC_POLY) : (crc_next >> 1);
        end
    end

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n)     crc_q <= '1;
        else if (clear) crc_q <= '1;
        else if (step)  crc_q <= crc_next;
    end
endmodule

// File: rtl/rxbd_ring_ptr.sv
// Current descriptor address of the ring.
// Assumes advance and load are not needed in the same cycle; load wins.
module rxbd_ring_ptr
    import rxbd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          advance,
    input  logic          wrap,
    output logic [AW-1:0] cur
);
    // Pointer update: reload, wrap to start, or step one descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n)       cur <= '0;
        else if (load)    cur <= base;
        else if (advance) cur <= wrap ? base : cur + AW'(DESC_STRIDE);
    end
endmodule

// File: rtl/rxbd_engine.sv
// Receive descriptor scatter engine: stores a byte stream plus CRC into
// a ring of buffer descriptors. Assumes memory accesses complete in the
// requesting cycle and a buffer size of at least 16 bytes.
module rxbd_engine
    import rxbd_pkg::*;
#(
    parameter int AW        = 32,
    parameter int BSW       = 11,
    parameter int MAX_FRAME = 2032
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [7:0]     in_data,
    input  logic           in_last,
    output logic           in_ready,
    output logic           mem_req,
    output logic           mem_we,
    output logic           mem_word,
    output logic [AW-1:0]  mem_addr,
    output logic [31:0]    mem_wdata,
    input  logic [31:0]    mem_rdata,
    input  logic           cfg_enable,
    input  logic [AW-1:0]  cfg_ring_base,
    input  logic           cfg_ring_load,
    input  logic [BSW-1:0] cfg_buf_size,
    input  logic [15:0]    cfg_max_len,
    input  logic           act_wr,
    output logic           rx_active,
    output logic           ev_frame,
    output logic           ev_buffer
);
    localparam int CW = $clog2(MAX_FRAME + 1);
    localparam logic [CW-1:0] PAY_MAX = CW'(MAX_FRAME - 4);

    rxbd_state_e    state;
    logic [BSW-1:0] cnt;
    logic [CW-1:0]  stored;
    logic           trunc, pay_done, fin_q;
    logic [1:0]     crc_idx;
    logic [31:0]    fcs, crc_next;
    logic [15:0]    flags_q, flags_new;
    logic [AW-1:0]  bufptr, cur;
    logic [BSW-1:0] bufsz;
    logic           take, room, wr_pay, wr_crc, wr_byte, final_byte, buf_full;
    logic           act_go, lg;
    logic [7:0]     byte_val;
    logic           unused_low;

    assign bufsz      = {cfg_buf_size[BSW-1:4], 4'b0};
    assign unused_low = ^cfg_buf_size[3:0];

    rxbd_crc u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state == ST_IDLE),
        .step     (take),
        .din      (in_data),
        .crc_next (crc_next)
    );

    rxbd_ring_ptr #(.AW(AW)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cfg_ring_load),
        .base    (cfg_ring_base),
        .advance (state == ST_WB),
        .wrap    (flags_q[BIT_WRAP]),
        .cur     (cur)
    );

    // Byte path decisions and write-back status word.
    always_comb begin
        take       = (state == ST_DATA) && !pay_done && in_valid;
        room       = stored < PAY_MAX;
        wr_pay     = take && room;
        wr_crc     = (state == ST_DATA) && pay_done;
        wr_byte    = wr_pay || wr_crc;
        final_byte = wr_crc && (crc_idx == 2'd3);
        buf_full   = (cnt + BSW'(1)) == bufsz;
        byte_val   = wr_crc ? fcs[8*crc_idx +: 8] : in_data;
        lg         = trunc || (32'(stored) > 32'(cfg_max_len));
        act_go     = act_wr && cfg_enable && !rx_active;
        flags_new  = flags_q;
        flags_new[BIT_EMPTY] = 1'b0;
        if (fin_q) begin
            flags_new[BIT_LAST] = 1'b1;
            if (trunc) flags_new[BIT_TRUNC]  = 1'b1;
            if (lg)    flags_new[BIT_LENERR] = 1'b1;
        end
    end

    // Memory port, input handshake and event pulses.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_word  = 1'b1;
        mem_addr  = cur;
        mem_wdata = '0;
        in_ready  = 1'b0;
        case (state)
            ST_IDLE:  in_ready = !rx_active && !act_go;
            ST_SKIP, ST_FLUSH: in_ready = 1'b1;
            ST_RD0, ST_CHK: mem_req = 1'b1;
            ST_RD1: begin
                mem_req  = 1'b1;
                mem_addr = cur + AW'(PTR_OFFSET);
            end
            ST_DATA: begin
                in_ready  = !pay_done;
                mem_req   = wr_byte;
                mem_we    = 1'b1;
                mem_word  = 1'b0;
                mem_addr  = bufptr + AW'(cnt);
                mem_wdata = {24'b0, byte_val};
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {flags_new, 16'(cnt)};
            end
            default: ;
        endcase
        ev_frame  = (state == ST_WB) && fin_q;
        ev_buffer = (state == ST_WB) && !fin_q;
    end

    // Control sequence and frame bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;  cnt <= '0;  stored <= '0;  trunc <= 1'b0;
            pay_done <= 1'b0;  fin_q <= 1'b0;  crc_idx <= '0;  fcs <= '0;
            flags_q <= '0;  bufptr <= '0;  rx_active <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (act_go) state <= ST_CHK;
                    else if (in_valid) begin
                        if (rx_active) begin
                            stored <= '0;  trunc <= 1'b0;  pay_done <= 1'b0;
                            fin_q <= 1'b0;  crc_idx <= '0;  state <= ST_RD0;
                        end else if (!in_last) state <= ST_SKIP;
                    end
                end
                ST_SKIP:  if (in_valid && in_last) state <= ST_IDLE;
                ST_RD0: begin
                    if (mem_rdata[16+BIT_EMPTY]) begin
                        flags_q <= mem_rdata[31:16];
                        state   <= ST_RD1;
                    end else if (pay_done) begin
                        rx_active <= 1'b0;
                        state     <= ST_IDLE;
                    end else state <= ST_FLUSH;
                end
                ST_RD1: begin
                    bufptr <= mem_rdata[AW-1:0];
                    cnt    <= '0;
                    state  <= ST_DATA;
                end
                ST_DATA: begin
                    if (take) begin
                        if (in_last) begin
                            pay_done <= 1'b1;
                            fcs      <= ~crc_next;
                        end
                        if (!room) trunc <= 1'b1;
                    end
                    if (wr_byte) begin
                        cnt    <= cnt + BSW'(1);
                        stored <= stored + CW'(1);
                        if (wr_crc) crc_idx <= crc_idx + 2'd1;
                        if (final_byte) fin_q <= 1'b1;
                        if (final_byte || buf_full) state <= ST_WB;
                    end
                end
                ST_WB:    state <= fin_q ? ST_CHK : ST_RD0;
                ST_FLUSH: if (in_valid && in_last) state <= ST_CHK;
                ST_CHK: begin
                    rx_active <= mem_rdata[16+BIT_EMPTY];
                    state     <= ST_IDLE;
                end
                default:  state <= ST_IDLE;
            endcase
            if (!cfg_enable) rx_active <= 1'b0;
        end
    end
endmodule

// File: rtl/rxbd_engine_chk.sv
// Protocol checker bound to the receive descriptor engine.
// Assumes the port names of rxbd_engine.
module rxbd_engine_chk #(
    parameter int AW  = 32,
    parameter int BSW = 11
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           in_ready,
    input logic           mem_req,
    input logic           mem_we,
    input logic           mem_word,
    input logic [31:0]    mem_wdata,
    input logic [BSW-1:0] cfg_buf_size,
    input logic           cfg_enable,
    input logic           rx_active,
    input logic           ev_frame,
    input logic           ev_buffer
);
    logic [15:0] bsz;
    assign bsz = 16'({cfg_buf_size[BSW-1:4], 4'b0});

    AST_BEAT_NO_DESC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && mem_req) |-> !mem_word);                       // R1
    AST_EVT_IS_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_frame || ev_buffer) |-> (mem_req && mem_we && mem_word && !mem_wdata[31])); // R5
    AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_frame && ev_buffer));                                              // R6
    AST_LAST_ONLY_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_frame || ev_buffer) |-> (mem_wdata[27] == ev_frame));               // R6
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_frame || ev_buffer) |-> (mem_wdata[15:0] <= bsz && mem_wdata[15:0] != 16'd0)); // R4
    AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !rx_active);                                            // R10
endmodule

bind rxbd_engine rxbd_engine_chk #(.AW(AW), .BSW(BSW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
    .mem_wdata(mem_wdata), .cfg_buf_size(cfg_buf_size),
    .cfg_enable(cfg_enable), .rx_active(rx_active),
    .ev_frame(ev_frame), .ev_buffer(ev_buffer)
);

// File: tb/rxbd_engine_test.sv
`timescale 1ns/1ps
module rxbd_engine_test;
    localparam int BASE = 256;
    localparam int MAXF = 2032;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_last = 1'b0, in_ready;
    logic [7:0]  in_data = '0;
    logic        mem_req, mem_we, mem_word;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        cfg_enable = 1'b0, cfg_ring_load = 1'b0, act_wr = 1'b0;
    logic [31:0] cfg_ring_base = BASE;
    logic [10:0] cfg_buf_size = 11'h04F;
    logic [15:0] cfg_max_len = 16'd1518;
    logic        rx_active, ev_frame, ev_buffer;

    always #4 clk = ~clk;

    rxbd_engine uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_word(mem_word), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .cfg_enable(cfg_enable), .cfg_ring_base(cfg_ring_base),
        .cfg_ring_load(cfg_ring_load), .cfg_buf_size(cfg_buf_size),
        .cfg_max_len(cfg_max_len), .act_wr(act_wr), .rx_active(rx_active),
        .ev_frame(ev_frame), .ev_buffer(ev_buffer)
    );

    int n_checks = 0, n_err = 0;
    bit finished = 1'b0;
    logic [7:0] mem [int];
    int wcount = 0, n_rxf = 0, n_rxb = 0, ready_bad = 0;

    function automatic logic [7:0] rd8(int a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction
    function automatic logic [15:0] rd16(int a);
        return {rd8(a), rd8(a + 1)};
    endfunction
    function automatic logic [31:0] rd32(int a);
        return {rd8(a), rd8(a + 1), rd8(a + 2), rd8(a + 3)};
    endfunction
    task automatic wr32(int a, logic [31:0] v);
        for (int k = 0; k < 4; k++) mem[a + k] = v[31 - 8*k -: 8];
    endtask
    function automatic logic [7:0] pb(int seed, int i);
        return 8'((seed * 13 + i * 7 + (i >> 3)) & 255);
    endfunction
    function automatic logic [31:0] fcs_of(int n, int seed);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            c ^= {24'b0, pb(seed, i)};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    // Memory model and per-cycle observation, mid-cycle away from edges.
    always @(negedge clk) begin
        #2;
        if (mem_req && !mem_we) mem_rdata = rd32(int'(mem_addr));
        if (mem_req && mem_we) begin
            if (mem_word) wr32(int'(mem_addr), mem_wdata);
            else mem[int'(mem_addr)] = mem_wdata[7:0];
            wcount++;
        end
        if (ev_frame) n_rxf++;
        if (ev_buffer) n_rxb++;
        if (mem_req && mem_word && in_ready) ready_bad++;
    end

    task automatic chk(bit ok, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // Behavioural reference state.
    int m_cur = BASE;
    bit m_active = 1'b0;
    int e_addr[$];  logic [7:0] e_val[$];  bit e_crc[$];
    int d_addr[$];  logic [31:0] d_word[$];
    int e_rxf, e_rxb;  bit e_act;

    task automatic model(int n, int seed);
        int paylen, total, pos, addr, bs, cnt;
        bit tr, lg, dropped, last;
        logic [31:0] fcs;  logic [15:0] fl, nf;  int ptr;
        logic [7:0] st[$];
        e_addr.delete(); e_val.delete(); e_crc.delete(); d_addr.delete(); d_word.delete();
        e_rxf = 0; e_rxb = 0;
        if (!m_active) begin e_act = 1'b0; return; end
        bs = int'(cfg_buf_size) & 32'h7F0;
        tr = n > MAXF - 4;
        paylen = tr ? MAXF - 4 : n;
        fcs = fcs_of(n, seed);
        for (int i = 0; i < paylen; i++) st.push_back(pb(seed, i));
        for (int k = 0; k < 4; k++) st.push_back(fcs[8*k +: 8]);
        total = paylen + 4;
        lg = tr || (total > int'(cfg_max_len));
        pos = 0; addr = m_cur; dropped = 1'b0;
        while (pos < total) begin
            fl = rd16(addr);
            if (!fl[15]) begin dropped = 1'b1; break; end
            ptr = int'(rd32(addr + 4));
            cnt = (total - pos < bs) ? total - pos : bs;
            for (int j = 0; j < cnt; j++) begin
                e_addr.push_back(ptr + j); e_val.push_back(st[pos + j]);
                e_crc.push_back(pos + j >= paylen);
            end
            pos += cnt;
            last = (pos == total);
            nf = fl & 16'h7FFF;
            if (last) nf |= 16'h0800 | (tr ? 16'h0001 : 16'h0) | (lg ? 16'h0020 : 16'h0);
            d_addr.push_back(addr); d_word.push_back({nf, 16'(cnt)});
            if (last) e_rxf++; else e_rxb++;
            addr = fl[13] ? BASE : addr + 8;
        end
        m_cur = addr;
        fl = rd16(addr);
        e_act = !dropped && fl[15];
        m_active = e_act;
    endtask

    task automatic send(int n, int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = pb(seed, i); in_last = (i == n - 1);
            #1;
            while (!in_ready) begin @(negedge clk); #1; end
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic run_frame(int n, int seed, string tag);
        int w0, perr, cerr;
        model(n, seed);
        n_rxf = 0; n_rxb = 0; ready_bad = 0; w0 = wcount;
        send(n, seed);
        repeat (16) @(negedge clk);
        perr = 0; cerr = 0;
        foreach (e_addr[i]) if (rd8(e_addr[i]) !== e_val[i]) begin
            if (e_crc[i]) cerr++; else perr++;
        end
        chk(perr == 0, {tag, " R1 payload bytes"}, perr, 0);
        chk(cerr == 0, {tag, " R2 check-sequence bytes"}, cerr, 0);
        foreach (d_addr[i])
            chk(rd32(d_addr[i]) === d_word[i], {tag, " R5 descriptor word"}, rd32(d_addr[i]), d_word[i]);
        chk(n_rxf == e_rxf, {tag, " R6 frame events"}, n_rxf, e_rxf);
        chk(n_rxb == e_rxb, {tag, " R6 buffer events"}, n_rxb, e_rxb);
        chk(rx_active === e_act, {tag, " R9 active after frame"}, rx_active, e_act);
        chk(ready_bad == 0, {tag, " R1 input held during descriptor access"}, ready_bad, 0);
        if (e_addr.size() == 0 && d_addr.size() == 0)
            chk(wcount == w0, {tag, " R9 no writes"}, wcount - w0, 0);
    endtask

    task automatic rearm();
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            wr32(BASE + 8*i, {(i == 3) ? 16'hA000 : 16'h8000, 16'h0});
            wr32(BASE + 8*i + 4, 32'h1000 + 32'h800 * i);
        end
    endtask

    task automatic set_owned(int a);
        logic [15:0] fl = rd16(a);
        @(negedge clk);
        wr32(a, {fl & 16'h7FFF, 16'h0});
    endtask

    task automatic activate();
        logic [15:0] fl = rd16(m_cur);
        if (cfg_enable && !m_active) m_active = fl[15];
        @(negedge clk); act_wr = 1'b1;
        @(negedge clk); act_wr = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    function automatic int nxt(int a);
        return (a == BASE + 24) ? BASE : a + 8;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int held;
        rearm();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #3;
        chk(rx_active === 1'b0, "R10 reset inactive", rx_active, 0);
        chk(mem_req === 1'b0, "R9 reset no access", mem_req, 0);
        cfg_ring_load = 1'b1; @(negedge clk); cfg_ring_load = 1'b0;
        activate();
        chk(rx_active === 1'b0, "R10 activate ignored while disabled", rx_active, 0);
        cfg_enable = 1'b1;
        activate();
        chk(rx_active === 1'b1, "R10 activate while enabled", rx_active, 1);

        run_frame(20, 1, "single");         rearm();
        run_frame(100, 2, "R4 split");      rearm();
        run_frame(62, 3, "R11 wrap");       rearm();
        run_frame(60, 4, "exact fit");      rearm();
        cfg_max_len = 16'd50;
        run_frame(60, 5, "R7 long");        rearm();
        cfg_max_len = 16'd1518;
        cfg_buf_size = 11'h7FF;
        run_frame(2040, 6, "R3 truncate");  rearm();
        cfg_buf_size = 11'h040;

        set_owned(nxt(m_cur));
        held = int'(rd32(nxt(m_cur)));
        run_frame(100, 7, "R8 owned mid-frame");
        chk(rd32(m_cur) === 32'(held), "R8 owned descriptor untouched", rd32(m_cur), held);
        chk(rx_active === 1'b0, "R8 inactive after discard", rx_active, 0);

        run_frame(30, 8, "R9 inactive drop");

        rearm();
        activate();
        chk(rx_active === 1'b1, "R10 reactivated", rx_active, 1);
        set_owned(nxt(m_cur));
        run_frame(20, 9, "R9 next owned");
        chk(rx_active === 1'b0, "R9 next descriptor owned", rx_active, 0);

        rearm();
        activate();
        chk(rx_active === 1'b1, "R10 active before disable", rx_active, 1);
        @(negedge clk); cfg_enable = 1'b0; m_active = 1'b0;
        @(negedge clk); #3;
        chk(rx_active === 1'b0, "R10 disable forces inactive", rx_active, 0);
        finish_run();
    end
endmodule